// File: doc/BRIEF.md
# Elastic Bit Store for Jitter Attenuation

This block is a one-bit-wide elastic store that sits in one serial path of a line channel. Bits are accepted on the line clock of the selected path and released on a separately supplied smoothed clock. Short-term phase wander between the two clocks is absorbed by the store's fill level. A two-bit mode field picks a shallow store, a deep store, or no store at all. A path-select input places the store in the receive path or in the transmit path. The other path, and both paths in bypass, pass data through unchanged.

After any flush or configuration change, the read side waits until the store is half full before it emits data. The shallow setting gives about half the delay of the deep one, so it suits delay-sensitive traffic and small amounts of wander. A sticky alarm reports a fill level that has come within a small gap of empty or of full. Pulsing the status strobe returns the alarm to zero and flushes the store, which then refills to half.

Top module: `dejit_bitstore`

## Requirements
- R1: After reset, `stat_limit` is 0 and the output of the path that holds the store is 0.
- R2: With `cfg_mode` 2'b00 or 2'b11, `rx_dout` equals `rx_din` and `tx_dout` equals `tx_din` in the same cycle, and `stat_limit` stays 0 even when a line clock stops.
- R3: `cfg_path_tx` = 0 writes the store on `rx_clk` from `rx_din` and drives `rx_dout` from it, with `tx_dout` following `tx_din` directly; `cfg_path_tx` = 1 swaps the roles of the two paths.
- R4: When the line clock and the smoothed clock run at the same rate, bits leave in the order they were written, with none lost or repeated.
- R5: After a flush or a change of `cfg_mode` or `cfg_path_tx`, the store output is 0 until the synchronized fill reaches half the depth; the steady delay is between D/2 and D/2+6 bits, with D = 16 for `cfg_mode` 2'b01 and D = 32 for 2'b10.
- R6: While running, `stat_limit` goes to 1 when the fill reaches D-2 or more, and stays 0 while the fill remains inside the band.
- R7: While running, `stat_limit` goes to 1 when the fill falls to 2 or less; on an empty store the read side holds its pointer rather than passing the write pointer.
- R8: Once set, `stat_limit` stays 1 until `stat_rd`, even after the fill has returned inside the band.
- R9: A one-cycle `stat_rd` clears `stat_limit` at the next `sm_clk` edge and flushes the store, after which the output refills and resumes in order.
- R10: The write pointer crosses into the smoothed-clock domain as Gray code, changing at most one bit per write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| rx_clk | input | 1 | Receive-path line clock |
| rx_din | input | 1 | Receive-path serial data in |
| rx_dout | output | 1 | Receive-path serial data out |
| tx_clk | input | 1 | Transmit-path line clock |
| tx_din | input | 1 | Transmit-path serial data in |
| tx_dout | output | 1 | Transmit-path serial data out |
| sm_clk | input | 1 | Smoothed read clock; also clocks the control and status port |
| cfg_mode | input | 2 | 00 bypass, 01 depth 16, 10 depth 32, 11 bypass |
| cfg_path_tx | input | 1 | 0 places the store in the receive path, 1 in the transmit path |
| stat_rd | input | 1 | Status read strobe: clears the alarm and flushes the store |
| stat_limit | output | 1 | Sticky near-limit alarm |

## Verification
Bypass and unselected-path results are combinational, so they are sampled 1 ns after the input changes. The alarm clear is due on the first `sm_clk` edge that sees `stat_rd`, so it is sampled one falling edge after the strobe. The alarm set must first pass the pointer synchronizer, so it is sampled after tens of smoothed cycles, well past the two-stage delay. Ordered delivery and delay are measured without cycle counting: the output history is matched against the logged input history at every candidate lag, and the lag that matches must fall in the window set by R5.

// File: rtl/dejit_pkg.sv
package dejit_pkg;

   typedef enum logic [1:0] {
      JA_BYPASS = 2'b00,
      JA_SHORT  = 2'b01,
      JA_LONG   = 2'b10,
      JA_RESVD  = 2'b11
   } ja_mode_e;

   function automatic logic mode_active(input logic [1:0] m);
      return (m == JA_SHORT) || (m == JA_LONG);
   endfunction

endpackage

// File: rtl/dejit_wr_side.sv
module dejit_wr_side #(
   parameter int MAX_DEPTH = 32,
   parameter int AW        = 5,
   parameter int PW        = 6
) (
   input  logic                 wr_clk,
   input  logic                 rst_n,
   input  logic                 din,
   output logic [MAX_DEPTH-1:0] store_o,
   output logic [PW-1:0]        wgray_o
);

   logic [PW-1:0] wbin_q;
   logic [PW-1:0] wbin_nx;

   assign wbin_nx = wbin_q + 1'b1;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray_o <= '0;
         store_o <= '0;
      end else begin
         store_o[wbin_q[AW-1:0]] <= din;
         wbin_q  <= wbin_nx;
         wgray_o <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

endmodule

// File: rtl/dejit_gray_sync.sv
module dejit_gray_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], gray_i};
   end

   always_comb begin
      logic [W-1:0] acc;
      acc[W-1] = chain_q[STAGES-1][W-1];
      for (int i = W - 2; i >= 0; i--) begin
         acc[i] = acc[i+1] ^ chain_q[STAGES-1][i];
      end
      bin_o = acc;
   end

endmodule

// File: rtl/dejit_rd_ctrl.sv
module dejit_rd_ctrl
   import dejit_pkg::*;
#(
   parameter int MAX_DEPTH   = 32,
   parameter int SHORT_DEPTH = 16,
   parameter int LIM_GAP     = 2,
   parameter int AW          = 5,
   parameter int PW          = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush_i,
   input  logic [1:0]           mode_i,
   input  logic                 path_i,
   input  logic [PW-1:0]        wbin_i,
   input  logic [MAX_DEPTH-1:0] store_i,
   output logic                 dat_o,
   output logic                 limit_o,
   output logic                 run_o,
   output logic [PW-1:0]        fill_o,
   output logic [PW-1:0]        depth_o
);

   localparam logic [PW-1:0] DEP_S = PW'(SHORT_DEPTH);
   localparam logic [PW-1:0] DEP_L = PW'(MAX_DEPTH);
   localparam logic [PW-1:0] GAP   = PW'(LIM_GAP);

   logic [PW-1:0] rbin_q;
   logic          run_q;
   logic          dat_q;
   logic          limit_q;
   logic [2:0]    cfg_q;
   logic          active;
   logic          restart;
   logic          near;

   assign active  = mode_active(mode_i);
   assign depth_o = (mode_i == JA_SHORT) ? DEP_S : DEP_L;
   assign fill_o  = wbin_i - rbin_q;
   assign restart = flush_i || !active || (cfg_q != {path_i, mode_i});
   assign near    = (fill_o <= GAP) || (fill_o >= depth_o - GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         run_q   <= 1'b0;
         dat_q   <= 1'b0;
         limit_q <= 1'b0;
         cfg_q   <= '0;
      end else begin
         cfg_q <= {path_i, mode_i};
         if (restart) begin
            rbin_q  <= wbin_i;
            run_q   <= 1'b0;
            dat_q   <= 1'b0;
            limit_q <= 1'b0;
         end else if (!run_q) begin
            run_q <= (fill_o >= (depth_o >> 1));
         end else begin
            if (fill_o != '0) begin
               dat_q  <= store_i[rbin_q[AW-1:0]];
               rbin_q <= rbin_q + 1'b1;
            end
            if (near) limit_q <= 1'b1;
         end
      end
   end

   assign dat_o   = dat_q;
   assign run_o   = run_q;
   assign limit_o = limit_q && active;

endmodule

// File: rtl/dejit_bitstore.sv
module dejit_bitstore
   import dejit_pkg::*;
#(
   parameter int MAX_DEPTH   = 32,
   parameter int SHORT_DEPTH = 16,
   parameter int LIM_GAP     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       rst_n,
   input  logic       rx_clk,
   input  logic       rx_din,
   output logic       rx_dout,
   input  logic       tx_clk,
   input  logic       tx_din,
   output logic       tx_dout,
   input  logic       sm_clk,
   input  logic [1:0] cfg_mode,
   input  logic       cfg_path_tx,
   input  logic       stat_rd,
   output logic       stat_limit
);

   localparam int AW = $clog2(MAX_DEPTH);
   localparam int PW = AW + 1;

   generate
      if (MAX_DEPTH != (1 << AW)) begin : g_bad_depth
         $error("MAX_DEPTH must be a power of two");
      end
      if (SHORT_DEPTH >= MAX_DEPTH || SHORT_DEPTH < 4) begin : g_bad_short
         $error("SHORT_DEPTH must lie in [4, MAX_DEPTH)");
      end
      if (LIM_GAP < 1 || LIM_GAP >= SHORT_DEPTH / 2) begin : g_bad_gap
         $error("LIM_GAP must lie in [1, SHORT_DEPTH/2)");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                 wr_clk;
   logic                 wr_din;
   logic                 active;
   logic [MAX_DEPTH-1:0] store_s;
   logic [PW-1:0]        wgray_s;
   logic [PW-1:0]        wbin_sync;
   logic                 fifo_dat;
   logic                 run_s;
   logic [PW-1:0]        fill_s;
   logic [PW-1:0]        depth_s;

   assign wr_clk = cfg_path_tx ? tx_clk : rx_clk;
   assign wr_din = cfg_path_tx ? tx_din : rx_din;
   assign active = mode_active(cfg_mode);

   dejit_wr_side #(
      .MAX_DEPTH(MAX_DEPTH), .AW(AW), .PW(PW)
   ) u_wr (
      .wr_clk (wr_clk),
      .rst_n  (rst_n),
      .din    (wr_din),
      .store_o(store_s),
      .wgray_o(wgray_s)
   );

   dejit_gray_sync #(
      .W(PW), .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk   (sm_clk),
      .rst_n (rst_n),
      .gray_i(wgray_s),
      .bin_o (wbin_sync)
   );

   dejit_rd_ctrl #(
      .MAX_DEPTH(MAX_DEPTH), .SHORT_DEPTH(SHORT_DEPTH), .LIM_GAP(LIM_GAP),
      .AW(AW), .PW(PW)
   ) u_rd (
      .clk    (sm_clk),
      .rst_n  (rst_n),
      .flush_i(stat_rd),
      .mode_i (cfg_mode),
      .path_i (cfg_path_tx),
      .wbin_i (wbin_sync),
      .store_i(store_s),
      .dat_o  (fifo_dat),
      .limit_o(stat_limit),
      .run_o  (run_s),
      .fill_o (fill_s),
      .depth_o(depth_s)
   );

   assign rx_dout = (active && !cfg_path_tx) ? fifo_dat : rx_din;
   assign tx_dout = (active &&  cfg_path_tx) ? fifo_dat : tx_din;

endmodule

// File: rtl/dejit_bitstore_chk.sv
module dejit_bitstore_chk #(
   parameter int PW        = 6,
   parameter int MAX_DEPTH = 32,
   parameter int LIM_GAP   = 2
) (
   input logic          sm_clk,
   input logic          wr_clk,
   input logic          rst_n,
   input logic          stat_rd,
   input logic          stat_limit,
   input logic [1:0]    cfg_mode,
   input logic          cfg_path_tx,
   input logic          run_s,
   input logic          fifo_dat,
   input logic [PW-1:0] fill_s,
   input logic [PW-1:0] depth_s,
   input logic [PW-1:0] wgray_s
);

   AST_GRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wgray_s ^ $past(wgray_s))); // R10

   AST_READ_CLEARS: assert property (@(posedge sm_clk) disable iff (!rst_n)
      stat_rd |=> !stat_limit); // R9

   AST_ALARM_CAUSE: assert property (@(posedge sm_clk) disable iff (!rst_n)
      $rose(stat_limit) |-> $past(run_s) &&
         (($past(fill_s) <= PW'(LIM_GAP)) || ($past(fill_s) >= $past(depth_s) - PW'(LIM_GAP)))); // R6

   AST_ALARM_STICKY: assert property (@(posedge sm_clk) disable iff (!rst_n)
      (stat_limit && !stat_rd && $stable(cfg_mode) && $stable(cfg_path_tx))
         |=> (stat_limit || !$stable(cfg_mode) || !$stable(cfg_path_tx))); // R8

   AST_RUN_AT_HALF: assert property (@(posedge sm_clk) disable iff (!rst_n)
      $rose(run_s) |-> ($past(fill_s) >= ($past(depth_s) >> 1))); // R5

   AST_SILENT_PREFILL: assert property (@(posedge sm_clk) disable iff (!rst_n)
      !run_s |-> !fifo_dat); // R5

   AST_NO_UNDERRUN: assert property (@(posedge sm_clk) disable iff (!rst_n)
      run_s |-> (fill_s <= PW'(MAX_DEPTH))); // R7

endmodule

bind dejit_bitstore dejit_bitstore_chk #(
   .PW(PW), .MAX_DEPTH(MAX_DEPTH), .LIM_GAP(LIM_GAP)
) u_chk (
   .sm_clk     (sm_clk),
   .wr_clk     (wr_clk),
   .rst_n      (rst_n),
   .stat_rd    (stat_rd),
   .stat_limit (stat_limit),
   .cfg_mode   (cfg_mode),
   .cfg_path_tx(cfg_path_tx),
   .run_s      (run_s),
   .fifo_dat   (fifo_dat),
   .fill_s     (fill_s),
   .depth_s    (depth_s),
   .wgray_s    (wgray_s)
);

// File: tb/dejit_bitstore_bench.sv
module dejit_bitstore_bench;

   logic       rst_n = 1'b0;
   logic       rx_clk = 1'b0, tx_clk = 1'b0, sm_clk = 1'b0;
   logic       rx_din = 1'b0, tx_din = 1'b0;
   logic [1:0] cfg_mode = 2'b01;
   logic       cfg_path_tx = 1'b0;
   logic       stat_rd = 1'b0;
   logic       rx_dout, tx_dout, stat_limit;

   bit rx_run = 1'b1, tx_run = 1'b1, sm_run = 1'b1, auto_drv = 1'b0;
   int n_chk = 0, n_fail = 0;

   logic [15:0] rx_lf = 16'hACE1, tx_lf = 16'h1D2B;
   bit   wr_log [1024];
   bit   out_log [1024];
   int   wc = 0, rc = 0;

   dejit_bitstore u_dejit_bitstore (
      .rst_n(rst_n), .rx_clk(rx_clk), .rx_din(rx_din), .rx_dout(rx_dout),
      .tx_clk(tx_clk), .tx_din(tx_din), .tx_dout(tx_dout), .sm_clk(sm_clk),
      .cfg_mode(cfg_mode), .cfg_path_tx(cfg_path_tx), .stat_rd(stat_rd),
      .stat_limit(stat_limit)
   );

   // 100 MHz smoothed clock; line clocks share the rate with fixed phase offsets
   initial forever begin #5; if (sm_run) sm_clk = ~sm_clk; end
   initial begin #2; forever begin #5; if (rx_run) rx_clk = ~rx_clk; end end
   initial begin #3; forever begin #5; if (tx_run) tx_clk = ~tx_clk; end end

   always @(negedge rx_clk) if (auto_drv) begin
      rx_lf  <= {rx_lf[14:0], rx_lf[15] ^ rx_lf[13] ^ rx_lf[12] ^ rx_lf[10]};
      rx_din <= rx_lf[15];
   end
   always @(negedge tx_clk) if (auto_drv) begin
      tx_lf  <= {tx_lf[14:0], tx_lf[15] ^ tx_lf[13] ^ tx_lf[12] ^ tx_lf[10]};
      tx_din <= tx_lf[15];
   end

   wire bwr_clk = cfg_path_tx ? tx_clk : rx_clk;
   wire bwr_din = cfg_path_tx ? tx_din : rx_din;

   always @(posedge bwr_clk) begin
      wr_log[wc % 1024] = bwr_din;
      wc++;
   end
   always @(negedge sm_clk) begin
      out_log[rc % 1024] = cfg_path_tx ? tx_dout : rx_dout;
      rc++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_sm(input int n);
      repeat (n) @(negedge sm_clk);
      #1;
   endtask

   task automatic find_lag(output int lag);
      int r = rc;
      int w = wc;
      lag = -1;
      for (int l = 0; l < 40; l++) begin
         bit ok = 1'b1;
         for (int j = 0; j < 48; j++) begin
            if (out_log[(r - 1 - j) % 1024] != wr_log[(w - 1 - l - j) % 1024]) ok = 1'b0;
         end
         if (ok && lag < 0) lag = l;
      end
   endtask

   task automatic check_stream(input string req, input int half);
      int lag;
      find_lag(lag);
      chk(lag >= 0, "R4 R10", {req, " ordered delivery"}, lag, half);
      chk(lag >= half && lag <= half + 6, "R5", {req, " delay window"}, lag, half);
   endtask

   task automatic t_reset();
      tx_din = 1'b1;
      rst_n  = 1'b0;
      wait_sm(5);
      rst_n = 1'b1;
      chk(stat_limit == 1'b0, "R1", "alarm after reset", stat_limit, 0);
      chk(rx_dout == 1'b0, "R1", "store output after reset", rx_dout, 0);
      chk(tx_dout == 1'b1, "R3", "unselected path follows input", tx_dout, 1);
   endtask

   task automatic t_bypass(input logic [1:0] m);
      auto_drv = 1'b0;
      cfg_mode = m;
      for (int v = 0; v < 2; v++) begin
         rx_din = v[0];
         tx_din = ~v[0];
         #1;
         chk(rx_dout == v[0], "R2", "bypass rx follows input", rx_dout, v);
         chk(tx_dout == ~v[0], "R2", "bypass tx follows input", tx_dout, 1 - v);
      end
      @(negedge sm_clk);
      rx_run = 1'b0;
      wait_sm(30);
      chk(stat_limit == 1'b0, "R2", "bypass alarm held low", stat_limit, 0);
      rx_run = 1'b1;
      wait_sm(5);
   endtask

   task automatic t_prefill_long();
      bit silent = 1'b1;
      @(negedge sm_clk);
      cfg_path_tx = 1'b0;
      cfg_mode    = 2'b10;
      auto_drv    = 1'b1;
      for (int k = 0; k < 12; k++) begin
         wait_sm(1);
         if (rx_dout !== 1'b0) silent = 1'b0;
      end
      chk(silent, "R5", "output silent during prefill", silent, 1);
      wait_sm(150);
      check_stream("deep", 16);
      chk(stat_limit == 1'b0, "R6", "no alarm in band (deep)", stat_limit, 0);
   endtask

   task automatic t_short();
      @(negedge sm_clk);
      cfg_mode = 2'b01;
      wait_sm(150);
      check_stream("shallow", 8);
      chk(stat_limit == 1'b0, "R6", "no alarm in band (shallow)", stat_limit, 0);
   endtask

   task automatic t_path_tx();
      @(negedge sm_clk);
      cfg_path_tx = 1'b1;
      wait_sm(150);
      check_stream("R3 tx path", 8);
      chk(rx_dout == rx_din, "R3", "rx passes through when store in tx", rx_dout, rx_din);
      @(negedge sm_clk);
      cfg_path_tx = 1'b0;
      wait_sm(150);
   endtask

   task automatic pulse_rd();
      @(negedge sm_clk);
      stat_rd = 1'b1;
      @(negedge sm_clk);
      stat_rd = 1'b0;
      #1;
   endtask

   task automatic t_underflow_sticky();
      @(negedge sm_clk);
      cfg_mode = 2'b10;
      wait_sm(150);
      @(negedge sm_clk);
      rx_run = 1'b0;
      wait_sm(40);
      chk(stat_limit == 1'b1, "R7", "alarm near empty", stat_limit, 1);
      @(negedge sm_clk);
      sm_run = 1'b0;
      rx_run = 1'b1;
      #120;
      sm_run = 1'b1;
      wait_sm(60);
      chk(stat_limit == 1'b1, "R8", "alarm sticky after recovery", stat_limit, 1);
      chk(stat_limit == 1'b1, "R9", "read sees alarm set", stat_limit, 1);
      pulse_rd();
      chk(stat_limit == 1'b0, "R9", "alarm cleared by read", stat_limit, 0);
      wait_sm(150);
      check_stream("R9 after flush", 16);
      chk(stat_limit == 1'b0, "R9", "alarm stays clear after flush", stat_limit, 0);
   endtask

   task automatic t_overflow();
      @(negedge sm_clk);
      cfg_mode = 2'b01;
      wait_sm(150);
      chk(stat_limit == 1'b0, "R6", "no alarm before overrun", stat_limit, 0);
      @(negedge sm_clk);
      sm_run = 1'b0;
      #80;
      sm_run = 1'b1;
      wait_sm(6);
      chk(stat_limit == 1'b1, "R6", "alarm near full", stat_limit, 1);
      pulse_rd();
      chk(stat_limit == 1'b0, "R9", "alarm cleared after overrun", stat_limit, 0);
   endtask

   initial begin
      #500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_bypass(2'b00);
      t_bypass(2'b11);
      t_prefill_long();
      t_short();
      t_path_tx();
      t_underflow_sticky();
      t_overflow();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule